// File: doc/BRIEF.md
# Watchdog Timer with Register Port

This block is a watchdog timer. Software sets it up and services it through three registers: control, count and status. The count register holds the reload value. The status register holds a down-counter that runs on every clock cycle while the watchdog is running. Software services the watchdog by writing the status register, which sets the counter back to the count value. If software does not service it in time, the counter falls from one to zero. The block then sets a sticky rollover flag and sends a one-cycle pulse on one of three event outputs: reset, non-maskable interrupt or general-purpose interrupt. Software can also choose no output.

The control register has an 8-bit run field. The watchdog stops only when that field holds one particular stop code. Any other value lets it run. While the watchdog runs, the count register is locked. While it is stopped, a count write also loads the status counter, so the next start begins from a known value. Each register access must use the byte-enable pattern that matches the register width. An access with the wrong pattern is rejected and flagged.

Top module: `wdt_top`

## Requirements
- R1: After reset, control reads 0x0AD0, count and status read 0, and all three event outputs are low.
- R2: The watchdog runs exactly when control bits [11:4] differ from 8'hAD. While it runs, status drops by one each cycle, starting the cycle after the control write that starts it. While it is stopped, status holds its value.
- R3: A count write (offset 0x4) while stopped stores the value and also copies it into status. While running, a count write is dropped and count keeps its old value.
- R4: While running, a status write (offset 0x8) sets status to the count value whatever data is written. While stopped, a status write changes nothing.
- R5: When status falls from 1 to 0, control bit 15 (rollover) becomes 1. Status then stays at 0 until it is reloaded.
- R6: On that same expiry, control bits [2:1] choose the output: 00 reset, 01 NMI, 10 GPI, 11 none. The chosen output is high for exactly one cycle, and the pulse becomes visible N cycles after the start when status started at N. The other outputs stay low.
- R7: A control write (offset 0x0) stores bits [14:0] as written. Writing 1 to bit 15 clears rollover, and writing 0 to bit 15 leaves it unchanged.
- R8: Control must be accessed with byte enables 4'b0011, and count and status with 4'b1111. Any other pattern sets bus_err, returns read data 0 and writes nothing.
- R9: A read at an unmapped or misaligned offset returns 0 without bus_err.
- R10: Read data and bus_err are registered. Both are valid in the cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Register access request, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_be | input | 4 | Byte enables of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| bus_err | output | 1 | Access rejected because of a wrong byte-enable pattern, one cycle after the request |
| evt_reset | output | 1 | Expiry pulse routed to reset |
| evt_nmi | output | 1 | Expiry pulse routed to NMI |
| evt_gpi | output | 1 | Expiry pulse routed to the general-purpose interrupt |

## Verification
The expiry path is swept over every routing code and every start value from 1 to 6. This shows whether the pulse lands in the right cycle, on the right output and only once. Status is read at set points after a start, and a nearby non-stop run code (0xAC) is used. These reads separate a counter that decrements from one that holds or starts a cycle late. Count and status are written in both the running and the stopped state, and control is written with bit 15 both set and clear. These writes separate locked updates, preloads, reloads and write-one-to-clear from plain storage. Wrong byte-enable patterns and misaligned or unmapped offsets show whether a rejected access can still leak into state.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int CTL_W  = 16;
  localparam int BUS_W  = 32;
  localparam int BE_W   = BUS_W / 8;
  localparam int N_EV   = 3;
  localparam int N_REG  = 3;

  localparam int SEL_LSB = 1;
  localparam int EN_LSB  = 4;
  localparam int EN_W    = 8;
  localparam int RO_BIT  = 15;

  localparam logic [EN_W-1:0]  STOP_CODE = 8'hAD;
  localparam logic [CTL_W-1:0] CTL_RST   = CTL_W'(STOP_CODE) << EN_LSB;

  localparam int IDX_CTL  = 0;
  localparam int IDX_CNT  = 1;
  localparam int IDX_STAT = 2;

  localparam logic [BE_W-1:0] BE_HALF = BE_W'(3);
  localparam logic [BE_W-1:0] BE_FULL = {BE_W{1'b1}};

  typedef enum logic [1:0] {
    EV_RESET = 2'd0,
    EV_NMI   = 2'd1,
    EV_GPI   = 2'd2,
    EV_NONE  = 2'd3
  } ev_sel_e;

  // Running unless the run field carries the stop code.
  function automatic logic ctl_running(input logic [CTL_W-1:0] c);
    return c[EN_LSB +: EN_W] != STOP_CODE;
  endfunction

  function automatic ev_sel_e ctl_target(input logic [CTL_W-1:0] c);
    return ev_sel_e'(c[SEL_LSB +: 2]);
  endfunction

  // Control update: plain bits follow the write, rollover is W1C, expiry sets it.
  function automatic logic [CTL_W-1:0] ctl_merge(input logic [CTL_W-1:0] cur,
                                                 input logic [CTL_W-1:0] wval,
                                                 input logic             we,
                                                 input logic             expire);
    logic [CTL_W-1:0] n;
    n = cur;
    if (we) begin
      n         = wval;
      n[RO_BIT] = cur[RO_BIT] & ~wval[RO_BIT];
    end
    if (expire) n[RO_BIT] = 1'b1;
    return n;
  endfunction

  function automatic logic [BE_W-1:0] be_needed(input int idx);
    return (idx == IDX_CTL) ? BE_HALF : BE_FULL;
  endfunction
endpackage

// File: rtl/wdt_regif.sv
module wdt_regif
  import wdt_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BE_W-1:0]   be,
  input  logic [CTL_W-1:0]  ctl_q,
  input  logic [CNT_W-1:0]  cnt_q,
  input  logic [CNT_W-1:0]  stat_q,
  output logic              ctl_we,
  output logic              cnt_we,
  output logic              stat_we,
  output logic [BUS_W-1:0]  rdata,
  output logic              err
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic             aligned;
  logic [N_REG-1:0] hit;
  logic [N_REG-1:0] be_ok;
  logic             width_ok;
  logic             bad;
  logic [N_REG-1:0] we_vec;
  logic [BUS_W-1:0] rd_word;

  assign idx     = addr[ADDR_W-1:2];
  assign aligned = (addr[1:0] == 2'b00);

  for (genvar g = 0; g < N_REG; g++) begin : g_dec
    assign hit[g]   = req && aligned && (idx == IDX_W'(g));
    assign be_ok[g] = (be == be_needed(g));
  end

  assign width_ok = ((hit & ~be_ok) == '0);
  assign bad      = (|hit) && !width_ok;
  assign we_vec   = hit & {N_REG{wr && width_ok}};

  assign ctl_we  = we_vec[IDX_CTL];
  assign cnt_we  = we_vec[IDX_CNT];
  assign stat_we = we_vec[IDX_STAT];

  always_comb begin
    rd_word = '0;
    if (!wr && width_ok) begin
      if (hit[IDX_CTL])  rd_word = BUS_W'(ctl_q);
      if (hit[IDX_CNT])  rd_word = BUS_W'(cnt_q);
      if (hit[IDX_STAT]) rd_word = BUS_W'(stat_q);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata <= '0;
      err   <= 1'b0;
    end else begin
      rdata <= (req && !wr) ? rd_word : '0;
      err   <= bad;
    end
  end
endmodule

// File: rtl/wdt_ctl.sv
module wdt_ctl
  import wdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] wval,
  input  logic             expire_now,
  output logic [CTL_W-1:0] ctl_q,
  output logic             run_en,
  output ev_sel_e          target
);
  always_ff @(posedge clk) begin
    if (!rst_n) ctl_q <= CTL_RST;
    else        ctl_q <= ctl_merge(ctl_q, wval, ctl_we, expire_now);
  end

  assign run_en = ctl_running(ctl_q);
  assign target = ctl_target(ctl_q);
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             cnt_we,
  input  logic             stat_we,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] stat_q,
  output logic             cnt_load,
  output logic             stat_reload,
  output logic             expire_now
);
  // Saturating step: zero stays zero.
  function automatic logic [CNT_W-1:0] stat_step(input logic [CNT_W-1:0] s);
    return (s == '0) ? s : s - CNT_W'(1);
  endfunction

  assign cnt_load    = cnt_we && !run_en;
  assign stat_reload = stat_we && run_en;
  assign expire_now  = run_en && !stat_reload && (stat_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      stat_q <= '0;
    end else if (cnt_load) begin
      cnt_q  <= load_val;
      stat_q <= load_val;
    end else if (stat_reload) begin
      stat_q <= cnt_q;
    end else if (run_en) begin
      stat_q <= stat_step(stat_q);
    end
  end
endmodule

// File: rtl/wdt_evt_router.sv
module wdt_evt_router
  import wdt_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            expire_now,
  input  ev_sel_e         target,
  output logic [N_EV-1:0] evt_q
);
  for (genvar g = 0; g < N_EV; g++) begin : g_out
    always_ff @(posedge clk) begin
      if (!rst_n) evt_q[g] <= 1'b0;
      else        evt_q[g] <= expire_now && (2'(target) == 2'(g));
    end
  end
endmodule

// File: rtl/wdt_top.sv
module wdt_top
  import wdt_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [3:0]        bus_be,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_err,
  output logic              evt_reset,
  output logic              evt_nmi,
  output logic              evt_gpi
);
  logic [CTL_W-1:0] ctl_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] stat_q;
  logic             ctl_we, cnt_we, stat_we;
  logic             run_en;
  logic             cnt_load, stat_reload, expire_now;
  ev_sel_e          target;
  logic [N_EV-1:0]  evt_q;

  wdt_regif #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regif (
    .clk(clk), .rst_n(rst_n), .req(bus_req), .wr(bus_wr), .addr(bus_addr),
    .be(bus_be), .ctl_q(ctl_q), .cnt_q(cnt_q), .stat_q(stat_q),
    .ctl_we(ctl_we), .cnt_we(cnt_we), .stat_we(stat_we),
    .rdata(bus_rdata), .err(bus_err)
  );

  wdt_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .wval(bus_wdata[CTL_W-1:0]),
    .expire_now(expire_now), .ctl_q(ctl_q), .run_en(run_en), .target(target)
  );

  wdt_counter #(.CNT_W(CNT_W)) u_counter (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .cnt_we(cnt_we),
    .stat_we(stat_we), .load_val(bus_wdata[CNT_W-1:0]),
    .cnt_q(cnt_q), .stat_q(stat_q), .cnt_load(cnt_load),
    .stat_reload(stat_reload), .expire_now(expire_now)
  );

  wdt_evt_router u_router (
    .clk(clk), .rst_n(rst_n), .expire_now(expire_now), .target(target),
    .evt_q(evt_q)
  );

  assign evt_reset = evt_q[EV_RESET];
  assign evt_nmi   = evt_q[EV_NMI];
  assign evt_gpi   = evt_q[EV_GPI];
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run_en,
  input logic [CNT_W-1:0] stat_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic             cnt_load,
  input logic             stat_reload,
  input logic [15:0]      ctl_q,
  input logic             evt_reset,
  input logic             evt_nmi,
  input logic             evt_gpi
);
  logic evt_any;
  assign evt_any = evt_reset | evt_nmi | evt_gpi;

  assert_evt_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({evt_reset, evt_nmi, evt_gpi}));

  assert_evt_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    evt_any |=> !evt_any);

  assert_ro_on_expiry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    evt_any |-> ctl_q[15]);

  assert_zero_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && stat_q == '0 && !stat_reload) |=> stat_q == '0);

  assert_frozen_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !cnt_load) |=> $stable(stat_q));

  assert_decrement_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && !stat_reload && stat_q != '0) |=> stat_q == $past(stat_q) - CNT_W'(1));

  assert_count_lock_R3: assert property (@(posedge clk) disable iff (!rst_n)
    run_en |=> $stable(cnt_q));

  assert_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
    stat_reload |=> stat_q == $past(cnt_q));
endmodule

bind wdt_top wdt_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run_en(run_en), .stat_q(stat_q), .cnt_q(cnt_q),
  .cnt_load(cnt_load), .stat_reload(stat_reload), .ctl_q(ctl_q),
  .evt_reset(evt_reset), .evt_nmi(evt_nmi), .evt_gpi(evt_gpi)
);

// File: tb/wdt_top_tb.sv
`timescale 1ns/1ps
module wdt_top_tb;
  localparam logic [3:0] A_CTL  = 4'h0;
  localparam logic [3:0] A_CNT  = 4'h4;
  localparam logic [3:0] A_STAT = 4'h8;
  localparam logic [3:0] HALF   = 4'b0011;
  localparam logic [3:0] FULL   = 4'b1111;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0, bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0, bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_err, evt_reset, evt_nmi, evt_gpi;

  int n_run = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  wdt_top u_dut (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_err(bus_err),
    .evt_reset(evt_reset), .evt_nmi(evt_nmi), .evt_gpi(evt_gpi)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d,
                           input logic [3:0] be, output logic e);
    bus_req = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(posedge clk); @(negedge clk);
    e = bus_err; bus_req = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, input logic [3:0] be,
                          output logic [31:0] d, output logic e);
    bus_req = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_be = be;
    @(posedge clk); @(negedge clk);
    d = bus_rdata; e = bus_err; bus_req = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic        e;
    logic [31:0] rd, rd2;
    logic [2:0]  ev;
    int pulses, pulse_at, wrong;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 events idle", {29'd0, evt_gpi, evt_nmi, evt_reset}, 32'd0);
    bus_read(A_CTL, HALF, rd, e);  check("R1 ctl reset", rd, 32'h0000_0AD0);
    check("R10 no err on valid read", {31'd0, e}, 32'd0);
    bus_read(A_CNT, FULL, rd, e);  check("R1 cnt reset", rd, 32'd0);
    bus_read(A_STAT, FULL, rd, e); check("R1 stat reset", rd, 32'd0);

    // R9 unmapped and misaligned
    bus_read(4'hC, FULL, rd, e); check("R9 unmapped data", rd, 32'd0);
    check("R9 unmapped err", {31'd0, e}, 32'd0);
    bus_read(4'h6, FULL, rd, e); check("R9 misaligned data", rd, 32'd0);

    // R8 byte-enable rules
    bus_read(A_CTL, FULL, rd, e);
    check("R8 ctl wide read err", {31'd0, e}, 32'd1);
    check("R8 ctl wide read data", rd, 32'd0);
    bus_write(A_CNT, 32'd5, HALF, e);
    check("R8 cnt half write err", {31'd0, e}, 32'd1);
    bus_read(A_CNT, FULL, rd, e); check("R8 cnt untouched", rd, 32'd0);
    bus_write(A_CTL, 32'h0000_0000, FULL, e);
    bus_read(A_CTL, HALF, rd, e); check("R8 ctl untouched", rd, 32'h0000_0AD0);

    // R3 preload while stopped, R4 status write ignored while stopped
    bus_write(A_CNT, 32'h0000_1234, FULL, e);
    bus_read(A_CNT, FULL, rd, e);  check("R3 cnt stored", rd, 32'h0000_1234);
    bus_read(A_STAT, FULL, rd, e); check("R3 stat preloaded", rd, 32'h0000_1234);
    bus_write(A_STAT, 32'h0000_0077, FULL, e);
    bus_read(A_STAT, FULL, rd, e); check("R4 stopped stat write ignored", rd, 32'h0000_1234);

    // R5 R6 R7 sweep over routing codes and start values
    for (int sel = 0; sel < 4; sel++) begin
      for (int n = 1; n <= 6; n++) begin
        bus_write(A_CNT, 32'(n), FULL, e);
        bus_write(A_CTL, 32'(sel << 1), HALF, e);
        pulses = 0; pulse_at = 0; wrong = 0;
        for (int i = 1; i <= n + 2; i++) begin
          @(negedge clk);
          ev = {evt_gpi, evt_nmi, evt_reset};
          if (ev != 3'd0) begin pulses++; pulse_at = i; end
          if ((ev & ~(3'(1) << sel)) != 3'd0) wrong++;
        end
        check("R6 pulse cycle", 32'(pulse_at), (sel == 3) ? 32'd0 : 32'(n));
        check("R6 routing and width", 32'(wrong * 16 + pulses), (sel == 3) ? 32'd0 : 32'd1);
        bus_read(A_CTL, HALF, rd, e);
        check("R5 rollover set", rd, 32'h8000 | 32'(sel << 1));
        bus_read(A_STAT, FULL, rd, e);
        check("R5 stat held at zero", rd, 32'd0);
        bus_write(A_CTL, 32'h0AD0 | 32'(sel << 1), HALF, e);
        bus_read(A_CTL, HALF, rd, e);
        check("R7 write zero keeps rollover", rd, 32'h8AD0 | 32'(sel << 1));
        bus_write(A_CTL, 32'h8AD0 | 32'(sel << 1), HALF, e);
        bus_read(A_CTL, HALF, rd, e);
        check("R7 write one clears rollover", rd, 32'h0AD0 | 32'(sel << 1));
      end
    end

    // R2 decrement rate, R4 reload, R3 lock while running
    bus_write(A_CNT, 32'd40, FULL, e);
    bus_write(A_CTL, 32'h0000_0006, HALF, e);
    repeat (5) @(negedge clk);
    bus_read(A_STAT, FULL, rd, e); check("R2 stat after 5 idle cycles", rd, 32'd35);
    bus_write(A_STAT, 32'h0000_DEAD, FULL, e);
    bus_read(A_STAT, FULL, rd, e); check("R4 running reload", rd, 32'd40);
    bus_write(A_CNT, 32'd7, FULL, e);
    check("R3 running cnt write no err", {31'd0, e}, 32'd0);
    bus_read(A_CNT, FULL, rd, e);  check("R3 running cnt locked", rd, 32'd40);
    bus_write(A_CTL, 32'h0000_0AD6, HALF, e);
    bus_read(A_STAT, FULL, rd, e);
    repeat (3) @(negedge clk);
    bus_read(A_STAT, FULL, rd2, e); check("R2 stopped stat frozen", rd2, rd);

    // R2 near-miss run code 0xAC still runs
    bus_write(A_CNT, 32'd100, FULL, e);
    bus_write(A_CTL, 32'h0000_0AC6, HALF, e);
    bus_read(A_STAT, FULL, rd, e);  check("R2 first read after start", rd, 32'd100);
    bus_read(A_STAT, FULL, rd, e);  check("R2 next cycle decremented", rd, 32'd99);
    check("R6 none selected stays quiet", {29'd0, evt_gpi, evt_nmi, evt_reset}, 32'd0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule